// File: doc/BRIEF.md
# Eight-Operation Small ALU

This block takes two unsigned 4-bit operands and a 3-bit operation code, and produces a 5-bit result. The eight operations are: pass-through, add, subtract, integer quotient, integer remainder, one-bit left shift, one-bit right shift and an unsigned greater-than test. The block produces no carry, overflow or other flag. Every result is cut down to its low five bits. Division and remainder with a zero divisor return fixed fallback values, so every input combination has a defined output.

By default the result passes through one output register with a synchronous active-high reset. This adds exactly one clock of latency. If the `OUT_REG` parameter is cleared, the same logic is purely combinational and `clk` and `rst` are not used. The operand width is a parameter, and the result is always one bit wider than the operands.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes 0 at that edge.
- R2: Code 3'b000 drives `a_i`, zero-extended, onto `res_o`.
- R3: Code 3'b001 drives the unsigned sum `a_i + b_i` (at most 30) onto `res_o`.
- R4: Code 3'b010 drives `a_i - b_i` computed modulo 32, so 3 - 5 gives 30.
- R5: Code 3'b011 drives the unsigned integer quotient `a_i / b_i`. When `b_i` is 0, the result is 5'b11111.
- R6: Code 3'b100 drives the remainder `a_i % b_i`. When `b_i` is 0, the result is `a_i`, zero-extended.
- R7: Code 3'b101 drives `a_i` shifted left by one. Bit 4 keeps the bit shifted out of `a_i`, and bit 0 is 0.
- R8: Code 3'b110 drives `a_i` shifted right by one, with zeros entering at the top (bits 4 and 3 are 0).
- R9: Code 3'b111 drives 1 when `a_i` is greater than `b_i` as unsigned values, and 0 otherwise.
- R10: With the default registered output, `res_o` shows the result for the inputs present at the previous rising edge, and it is unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 4 | First unsigned operand |
| b_i | input | 4 | Second unsigned operand |
| op_i | input | 3 | Operation code |
| res_o | output | 5 | Result, low five bits |

## Verification
A short table of hand-worked cases covers the points where the result stops following plain arithmetic:
- subtraction that wraps below zero;
- a zero divisor under both divide codes;
- shifts that move a set bit into bit 4 or out of bit 0;
- the compare at equal operands.

After the table, the bench applies every pair of operands under every code and compares against an arithmetic model. This separates an error in one operation from a wrong select decode. Directed checks then apply reset while the inputs would give a nonzero result, and sample the output between edges to confirm the one-cycle latency.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_DIV  = 3'd3,
    OP_REM  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_GT   = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned OPW = 4,
  localparam int unsigned RW = OPW + 1
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [RW-1:0]  sum,
  output logic [RW-1:0]  diff
);
  // Both results are formed one bit wider than the operands; the
  // difference wraps modulo 2**RW when b exceeds a.
  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};
endmodule

// File: rtl/alu8_divmod.sv
module alu8_divmod #(
  parameter int unsigned OPW = 4,
  localparam int unsigned RW = OPW + 1
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [RW-1:0]  quo,
  output logic [RW-1:0]  rem
);
  logic b_zero;
  assign b_zero = (b == '0);

  always_comb begin
    if (b_zero) begin
      quo = '1;
      rem = {1'b0, a};
    end else begin
      quo = {1'b0, a / b};
      rem = {1'b0, a % b};
    end
  end
endmodule

// File: rtl/alu8_shcmp.sv
module alu8_shcmp #(
  parameter int unsigned OPW = 4,
  localparam int unsigned RW = OPW + 1
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [RW-1:0]  shl,
  output logic [RW-1:0]  shr,
  output logic [RW-1:0]  gt
);
  assign shl = {a, 1'b0};
  assign shr = {2'b00, a[OPW-1:1]};
  assign gt  = {{(RW-1){1'b0}}, (a > b)};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned OPW     = 4,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned RW     = OPW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic [2:0]     op_i,
  output logic [RW-1:0]  res_o
);
  logic [RW-1:0] sum_w, diff_w, quo_w, rem_w, shl_w, shr_w, gt_w;
  logic [RW-1:0] nxt_res;
  alu_op_e       op_sel;

  assign op_sel = alu_op_e'(op_i);

  alu8_addsub #(.OPW(OPW)) u_addsub (
    .a(a_i), .b(b_i), .sum(sum_w), .diff(diff_w)
  );

  alu8_divmod #(.OPW(OPW)) u_divmod (
    .a(a_i), .b(b_i), .quo(quo_w), .rem(rem_w)
  );

  alu8_shcmp #(.OPW(OPW)) u_shcmp (
    .a(a_i), .b(b_i), .shl(shl_w), .shr(shr_w), .gt(gt_w)
  );

  always_comb begin
    unique case (op_sel)
      OP_PASS: nxt_res = {1'b0, a_i};
      OP_ADD:  nxt_res = sum_w;
      OP_SUB:  nxt_res = diff_w;
      OP_DIV:  nxt_res = quo_w;
      OP_REM:  nxt_res = rem_w;
      OP_SHL:  nxt_res = shl_w;
      OP_SHR:  nxt_res = shr_w;
      OP_GT:   nxt_res = gt_w;
      default: nxt_res = '0;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [RW-1:0] res_q;
      always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt_res;
      end
      assign res_o = res_q;
    end else begin : g_comb
      assign res_o = nxt_res;
    end
  endgenerate
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int unsigned OPW     = 4,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned RW     = OPW + 1
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] a_i,
  input logic [OPW-1:0] b_i,
  input logic [2:0]     op_i,
  input logic [RW-1:0]  res_o
);
  generate
    if (OUT_REG) begin : g_props
      // R2
      pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |=> (res_o == {1'b0, $past(a_i)}));

      // R5
      div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 && b_i == '0) |=> (res_o == '1));

      // R6
      rem_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && b_i == '0) |=> (res_o == {1'b0, $past(a_i)}));

      // R7
      shl_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5) |=> (res_o[0] == 1'b0 && res_o[RW-1] == $past(a_i[OPW-1])));

      // R8
      shr_top_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd6) |=> (res_o[RW-1:RW-2] == 2'b00));

      // R9
      cmp_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd7) |=> (res_o == {{(RW-1){1'b0}}, ($past(a_i) > $past(b_i))}));

      // R10
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(a_i) && $stable(b_i) && $stable(op_i)) |=> $stable(res_o));
    end
  endgenerate
endmodule

bind alu8_core alu8_chk #(.OPW(OPW), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_i = '0;
  logic [3:0] b_i = '0;
  logic [2:0] op_i = '0;
  logic [4:0] res_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_o)
  );

  // {req, op, a, b, expected}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2,  3'd0, 4'd9,  4'd3,  5'd9},   // R2
    {4'd3,  3'd1, 4'd15, 4'd15, 5'd30},  // R3
    {4'd4,  3'd2, 4'd3,  4'd5,  5'd30},  // R4 wrap
    {4'd4,  3'd2, 4'd12, 4'd4,  5'd8},   // R4
    {4'd5,  3'd3, 4'd13, 4'd4,  5'd3},   // R5
    {4'd5,  3'd3, 4'd7,  4'd0,  5'd31},  // R5 zero divisor
    {4'd6,  3'd4, 4'd13, 4'd4,  5'd1},   // R6
    {4'd6,  3'd4, 4'd11, 4'd0,  5'd11},  // R6 zero divisor
    {4'd7,  3'd5, 4'd15, 4'd2,  5'd30},  // R7
    {4'd7,  3'd5, 4'd9,  4'd0,  5'd18},  // R7
    {4'd8,  3'd6, 4'd15, 4'd0,  5'd7},   // R8
    {4'd9,  3'd7, 4'd5,  4'd4,  5'd1},   // R9
    {4'd9,  3'd7, 4'd4,  4'd4,  5'd0},   // R9 equal
    {4'd9,  3'd7, 4'd0,  4'd15, 5'd0}    // R9
  };

  function automatic logic [4:0] ref_alu(input int op, input int a, input int b);
    int r;
    case (op)
      0: r = a;
      1: r = a + b;
      2: r = (a - b + 32) % 32;
      3: r = (b == 0) ? 31 : a / b;
      4: r = (b == 0) ? a : a % b;
      5: r = (a * 2) % 32;
      6: r = a / 2;
      default: r = (a > b) ? 1 : 0;
    endcase
    return r[4:0];
  endfunction

  task automatic check(input int req, input logic [4:0] exp_v);
    checks++;
    if (res_o !== exp_v) begin
      fails++;
      $display("FAIL R%0d: res_o=%0d expected=%0d (op=%0d a=%0d b=%0d)",
               req, res_o, exp_v, op_i, a_i, b_i);
    end
  endtask

  task automatic apply(input int op, input int a, input int b);
    @(negedge clk);
    op_i = op[2:0]; a_i = a[3:0]; b_i = b[3:0];
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    op_i = 3'd1; a_i = 4'd7; b_i = 4'd7;
    repeat (3) @(negedge clk);
    check(1, 5'd0);
    rst = 1'b0;

    // Table of directed vectors
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5]);
      check(VEC[i][19:16], VEC[i][4:0]);
    end

    // Full sweep against the arithmetic model; requirement = op + 2
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(op, a, b);
          check(op + 2, ref_alu(op, a, b));
        end

    // R10: output holds the old result until the next rising edge
    apply(1, 6, 5);
    check(10, 5'd11);
    op_i = 3'd0; a_i = 4'd2;
    #2;
    check(10, 5'd11);
    @(negedge clk);
    check(10, 5'd2);

    // R1: reset applied mid-run while inputs would give nonzero
    @(negedge clk);
    op_i = 3'd1; a_i = 4'd9; b_i = 4'd9; rst = 1'b1;
    @(negedge clk);
    check(1, 5'd0);
    rst = 1'b0;
    @(negedge clk);
    check(3, 5'd18);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule